// File: doc/BRIEF.md
# Camera Frame Capture Sequencer

This block is the control core of a bridge between a slow host processor and a fast camera sensor. The host picks a resolution code and a colour mode, then raises a start pin. The block latches the selection and programs the sensor through a separate register-write command port, so the host never handles sensor setup. It wakes the sensor and lets a separate pixel capture block fill an on-chip frame buffer.

While the frame is being collected, the host-side address and data pads are disabled. Once the capture block reports the last pixel, the block raises a frame-ready flag and sends the sensor a sleep command. It then serves random byte reads from the host. A rising edge on a second request pin starts another capture with the latched settings, skipping the configuration writes.

The start and request pins are asynchronous to the control clock. Each passes through a synchroniser and an edge detector. An edge that arrives in a state where it has no meaning is dropped.

Top module: `capture_sequencer_top`

## Requirements
- R1: While and right after `rst` is high, `frame_ready_o`, `host_bus_en_o`, `cmd_req_o` and `cap_start_o` are 0, and `host_data_o` is 0.
- R2: A rising edge on `init_i` in the idle state first produces three register writes in this order: (0x0A, 0x80), (0x20, 0x04 for RGB or 0x00 for gray), (0x21, zero-extended 2-bit size code). A wake write (0x3C, 0x00) follows. Then `cap_start_o` pulses for exactly one cycle.
- R3: `cmd_req_o` is a single-cycle pulse that is only raised while `cmd_busy_i` is low. The next pulse waits until the port has dropped busy after the previous one.
- R4: From the start of a capture until the frame-done report, `host_bus_en_o` is 0 and `host_data_o` stays 0, whatever `host_rd_n_i` does.
- R5: A `cap_done_i` pulse during capture raises `frame_ready_o` and `host_bus_en_o` on the next clock edge. The next command is then the sleep write (0x3C, 0x01), and after it no further command is issued.
- R6: With the bus enabled, holding `host_rd_n_i` low with address A at a clock edge puts the byte stored at A on `host_data_o` after that edge.
- R7: Writes on the capture port while no capture is running are discarded and leave the buffer unchanged.
- R8: A rising edge on `req_frame_i` after the sleep write clears `frame_ready_o` and issues only the wake write before a new `cap_start_o` pulse.
- R9: An `init_i` edge outside idle and a `req_frame_i` edge outside the ready state cause no command and no capture start.
- R10: `cap_size_o` and `cap_rgb_o` keep the values latched at the `init_i` edge until the next reset, even when the selection pins change afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous active-high reset |
| size_sel_i | input | 2 | Resolution code, latched at start |
| rgb_sel_i | input | 1 | 1 = RGB, 0 = gray, latched at start |
| init_i | input | 1 | Asynchronous first-capture start |
| req_frame_i | input | 1 | Asynchronous repeat-capture request |
| cmd_busy_i | input | 1 | Register-write port busy |
| cmd_req_o | output | 1 | Register-write request pulse |
| cmd_addr_o | output | 8 | Sensor register address |
| cmd_data_o | output | 8 | Sensor register value |
| cap_start_o | output | 1 | Capture block start pulse |
| cap_size_o | output | 2 | Latched resolution code |
| cap_rgb_o | output | 1 | Latched colour mode |
| cap_we_i | input | 1 | Pixel write strobe from capture block |
| cap_addr_i | input | 10 | Pixel write address |
| cap_data_i | input | 8 | Pixel byte |
| cap_done_i | input | 1 | Frame complete pulse |
| frame_ready_o | output | 1 | Frame stored flag |
| host_bus_en_o | output | 1 | Host pad enable, 0 = high impedance |
| host_rd_n_i | input | 1 | Active-low host read strobe |
| host_addr_i | input | 10 | Host read address |
| host_data_o | output | 8 | Host read data |

## Verification
The hardest situations to reach are the stray edges. One is a request edge that lands mid-capture. Another is a start edge that lands after the frame is stored. Capture-port writes after the frame is done are a third. Each needs the sequencer parked in a particular state, which is only visible through the command log and the ready flag. The bench therefore runs every size and colour combination through a full capture. It fires request pulses between the capture-start pulse and the pixel stream, and start pulses and late writes once the sleep write has gone out. It then checks the command log, the start-pulse count and buffer read-back to show nothing moved.

// File: rtl/capture_seq_pkg.sv
package capture_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_CONFIG  = 3'd1,
    ST_WAKE    = 3'd2,
    ST_CAPTURE = 3'd3,
    ST_SLEEP   = 3'd4,
    ST_READY   = 3'd5
  } seq_state_t;

  typedef struct packed {
    logic [1:0] size;
    logic       rgb;
  } cap_cfg_t;

  localparam int CMD_W   = 8;
  localparam int N_CFG   = 3;
  localparam int IDX_W   = 2;

  localparam logic [CMD_W-1:0] RA_CTRL  = 8'h0A;
  localparam logic [CMD_W-1:0] RA_FMT   = 8'h20;
  localparam logic [CMD_W-1:0] RA_SIZE  = 8'h21;
  localparam logic [CMD_W-1:0] RA_POWER = 8'h3C;

  localparam logic [CMD_W-1:0] RV_SOFT_RESET = 8'h80;
  localparam logic [CMD_W-1:0] RV_FMT_RGB    = 8'h04;
  localparam logic [CMD_W-1:0] RV_FMT_GRAY   = 8'h00;
  localparam logic [CMD_W-1:0] RV_AWAKE      = 8'h00;
  localparam logic [CMD_W-1:0] RV_ASLEEP     = 8'h01;

endpackage

// File: rtl/sync_edge.sv
module sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES:0] shr_q;

  always_ff @(posedge clk) begin
    if (rst) shr_q <= '0;
    else     shr_q <= {shr_q[STAGES-1:0], async_i};
  end

  assign rise_o = shr_q[STAGES-1] & ~shr_q[STAGES];

  p_rise_single_r9: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/cmd_table.sv
module cmd_table
  import capture_seq_pkg::*;
(
  input  seq_state_t       state_i,
  input  logic [IDX_W-1:0] idx_i,
  input  cap_cfg_t         cfg_i,
  output logic [CMD_W-1:0] addr_o,
  output logic [CMD_W-1:0] data_o,
  output logic [IDX_W-1:0] last_idx_o
);
  always_comb begin
    addr_o     = RA_POWER;
    data_o     = RV_AWAKE;
    last_idx_o = '0;
    unique case (state_i)
      ST_CONFIG: begin
        last_idx_o = IDX_W'(N_CFG - 1);
        case (idx_i)
          2'd0: begin addr_o = RA_CTRL; data_o = RV_SOFT_RESET; end
          2'd1: begin addr_o = RA_FMT;  data_o = cfg_i.rgb ? RV_FMT_RGB : RV_FMT_GRAY; end
          default: begin addr_o = RA_SIZE; data_o = {{(CMD_W-2){1'b0}}, cfg_i.size}; end
        endcase
      end
      ST_SLEEP: begin addr_o = RA_POWER; data_o = RV_ASLEEP; end
      default:  begin addr_o = RA_POWER; data_o = RV_AWAKE;  end
    endcase
  end
endmodule

// File: rtl/frame_ram.sv
module frame_ram #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_en_i,
  input  logic              clr_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) rdata_o <= '0;
    else if (rd_en_i) rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import capture_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             init_rise_i,
  input  logic             req_rise_i,
  input  logic [1:0]       size_i,
  input  logic             rgb_i,
  input  logic             cmd_busy_i,
  input  logic             cap_done_i,
  output logic             cmd_req_o,
  output logic [CMD_W-1:0] cmd_addr_o,
  output logic [CMD_W-1:0] cmd_data_o,
  output logic             cap_start_o,
  output cap_cfg_t         cfg_o,
  output logic             frame_ready_o,
  output logic             bus_en_o,
  output seq_state_t       state_o
);
  seq_state_t       state_q;
  cap_cfg_t         cfg_q;
  logic [IDX_W-1:0] idx_q;
  logic             wait_q, guard_q;
  logic [CMD_W-1:0] tbl_addr, tbl_data;
  logic [IDX_W-1:0] last_idx;
  seq_state_t       next_after_cmd;

  cmd_table u_tbl (
    .state_i   (state_q),
    .idx_i     (idx_q),
    .cfg_i     (cfg_q),
    .addr_o    (tbl_addr),
    .data_o    (tbl_data),
    .last_idx_o(last_idx)
  );

  always_comb begin
    unique case (state_q)
      ST_CONFIG: next_after_cmd = ST_WAKE;
      ST_WAKE:   next_after_cmd = ST_CAPTURE;
      default:   next_after_cmd = ST_READY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      cfg_q         <= '0;
      idx_q         <= '0;
      wait_q        <= 1'b0;
      guard_q       <= 1'b0;
      cmd_req_o     <= 1'b0;
      cmd_addr_o    <= '0;
      cmd_data_o    <= '0;
      cap_start_o   <= 1'b0;
      frame_ready_o <= 1'b0;
      bus_en_o      <= 1'b0;
    end else begin
      cmd_req_o   <= 1'b0;
      cap_start_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (init_rise_i) begin
            cfg_q         <= '{size: size_i, rgb: rgb_i};
            idx_q         <= '0;
            wait_q        <= 1'b0;
            frame_ready_o <= 1'b0;
            bus_en_o      <= 1'b0;
            state_q       <= ST_CONFIG;
          end
        end
        ST_CONFIG, ST_WAKE, ST_SLEEP: begin
          if (!wait_q) begin
            if (!cmd_busy_i) begin
              cmd_req_o  <= 1'b1;
              cmd_addr_o <= tbl_addr;
              cmd_data_o <= tbl_data;
              wait_q     <= 1'b1;
              guard_q    <= 1'b1;
            end
          end else if (guard_q) begin
            guard_q <= 1'b0;
          end else if (!cmd_busy_i) begin
            wait_q <= 1'b0;
            if (idx_q == last_idx) begin
              idx_q   <= '0;
              state_q <= next_after_cmd;
              if (next_after_cmd == ST_CAPTURE) cap_start_o <= 1'b1;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        ST_CAPTURE: begin
          if (cap_done_i) begin
            frame_ready_o <= 1'b1;
            bus_en_o      <= 1'b1;
            state_q       <= ST_SLEEP;
          end
        end
        ST_READY: begin
          if (req_rise_i) begin
            frame_ready_o <= 1'b0;
            bus_en_o      <= 1'b0;
            idx_q         <= '0;
            wait_q        <= 1'b0;
            state_q       <= ST_WAKE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cfg_o   = cfg_q;
  assign state_o = state_q;

  p_req_when_free_r3: assert property (@(posedge clk) disable iff (rst)
    cmd_req_o |-> !cmd_busy_i);
  p_req_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    cmd_req_o |=> !cmd_req_o);
  p_start_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    cap_start_o |=> !cap_start_o);
  p_bus_off_capture_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CAPTURE) |-> !bus_en_o);
  p_ready_after_done_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_ready_o) |-> $past(cap_done_i));
  p_cfg_held_r10: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE) |=> $stable(cfg_q));
endmodule

// File: rtl/capture_sequencer_top.sv
module capture_sequencer_top
  import capture_seq_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        size_sel_i,
  input  logic              rgb_sel_i,
  input  logic              init_i,
  input  logic              req_frame_i,
  input  logic              cmd_busy_i,
  output logic              cmd_req_o,
  output logic [CMD_W-1:0]  cmd_addr_o,
  output logic [CMD_W-1:0]  cmd_data_o,
  output logic              cap_start_o,
  output logic [1:0]        cap_size_o,
  output logic              cap_rgb_o,
  input  logic              cap_we_i,
  input  logic [ADDR_W-1:0] cap_addr_i,
  input  logic [DATA_W-1:0] cap_data_i,
  input  logic              cap_done_i,
  output logic              frame_ready_o,
  output logic              host_bus_en_o,
  input  logic              host_rd_n_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  output logic [DATA_W-1:0] host_data_o
);
  localparam int N_ASYNC = 2;

  logic [N_ASYNC-1:0] async_pins, rises;
  seq_state_t         state;
  cap_cfg_t           cfg;
  logic               mem_we, rd_en;

  assign async_pins = {req_frame_i, init_i};

  for (genvar g = 0; g < N_ASYNC; g++) begin : g_sync
    sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst    (rst),
      .async_i(async_pins[g]),
      .rise_o (rises[g])
    );
  end

  seq_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .init_rise_i  (rises[0]),
    .req_rise_i   (rises[1]),
    .size_i       (size_sel_i),
    .rgb_i        (rgb_sel_i),
    .cmd_busy_i   (cmd_busy_i),
    .cap_done_i   (cap_done_i),
    .cmd_req_o    (cmd_req_o),
    .cmd_addr_o   (cmd_addr_o),
    .cmd_data_o   (cmd_data_o),
    .cap_start_o  (cap_start_o),
    .cfg_o        (cfg),
    .frame_ready_o(frame_ready_o),
    .bus_en_o     (host_bus_en_o),
    .state_o      (state)
  );

  assign mem_we = cap_we_i && (state == ST_CAPTURE);
  assign rd_en  = !host_rd_n_i && host_bus_en_o;

  frame_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk    (clk),
    .rst    (rst),
    .we_i   (mem_we),
    .waddr_i(cap_addr_i),
    .wdata_i(cap_data_i),
    .rd_en_i(rd_en),
    .clr_i  (!host_bus_en_o),
    .raddr_i(host_addr_i),
    .rdata_o(host_data_o)
  );

  assign cap_size_o = cfg.size;
  assign cap_rgb_o  = cfg.rgb;

  p_no_write_while_served_r7: assert property (@(posedge clk) disable iff (rst)
    host_bus_en_o |-> !mem_we);
  p_data_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (!host_bus_en_o && !$rose(host_bus_en_o) && $past(!host_bus_en_o)) |-> (host_data_o == '0));
endmodule

// File: tb/capture_sequencer_tb.sv
module capture_sequencer_top_tb_top;
  localparam int AW = 10;
  localparam int BUSY_LAT = 3;

  logic clk = 0;
  logic rst = 1;
  logic [1:0] size_sel = 0;
  logic rgb_sel = 0, init_p = 0, req_p = 0, cmd_busy = 0;
  logic cap_we = 0, cap_done = 0, rd_n = 1;
  logic [AW-1:0] cap_addr = 0, haddr = 0;
  logic [7:0] cap_data = 0;
  logic cmd_req, cap_start, cap_rgb, frame_ready, bus_en;
  logic [7:0] cmd_addr, cmd_data, host_data;
  logic [1:0] cap_size;

  int n_checks = 0, n_err = 0, cyc = 0;
  int cmd_n = 0, start_n = 0, busy_cnt = 0;
  logic [15:0] cmd_log [256];
  bit done_flag = 0;

  always #2 clk = ~clk;

  capture_sequencer_top dut_i (
    .clk(clk), .rst(rst), .size_sel_i(size_sel), .rgb_sel_i(rgb_sel),
    .init_i(init_p), .req_frame_i(req_p), .cmd_busy_i(cmd_busy),
    .cmd_req_o(cmd_req), .cmd_addr_o(cmd_addr), .cmd_data_o(cmd_data),
    .cap_start_o(cap_start), .cap_size_o(cap_size), .cap_rgb_o(cap_rgb),
    .cap_we_i(cap_we), .cap_addr_i(cap_addr), .cap_data_i(cap_data),
    .cap_done_i(cap_done), .frame_ready_o(frame_ready), .host_bus_en_o(bus_en),
    .host_rd_n_i(rd_n), .host_addr_i(haddr), .host_data_o(host_data)
  );

  // command port model and event counters
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cap_start) start_n <= start_n + 1;
    if (cmd_req) begin
      cmd_log[cmd_n[7:0]] <= {cmd_addr, cmd_data};
      cmd_n    <= cmd_n + 1;
      cmd_busy <= 1'b1;
      busy_cnt <= BUSY_LAT;
    end else if (busy_cnt > 1) begin
      busy_cnt <= busy_cnt - 1;
    end else begin
      busy_cnt <= 0;
      cmd_busy <= 1'b0;
    end
  end

  function automatic logic [7:0] pix(int a, int f);
    return 8'((a * 37 + f * 11 + 5) & 255);
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_start(output bit ok);
    ok = 0;
    for (int i = 0; i < 2000 && !ok; i++) begin
      @(negedge clk);
      if (cap_start) ok = 1;
    end
  endtask

  task automatic wait_ready(logic v);
    for (int i = 0; i < 2000 && frame_ready != v; i++) @(negedge clk);
  endtask

  task automatic send_frame(int npix, int f);
    for (int i = 0; i < npix; i++) begin
      @(negedge clk);
      cap_we = 1; cap_addr = AW'(i); cap_data = pix(i, f);
    end
    @(negedge clk); cap_we = 0; cap_done = 1;
    @(negedge clk); cap_done = 0;
  endtask

  task automatic read_chk(int a, int exp, string tag);
    @(negedge clk); rd_n = 0; haddr = AW'(a);
    @(negedge clk); rd_n = 1;
    chk(tag, host_data, exp);
  endtask

  task automatic run_cfg(int s, int m);
    int base, st0, npix, f;
    bit ok;
    npix = 16 << s;
    f = s * 2 + m;
    // R1 reset state
    @(negedge clk); rst = 1;
    repeat (3) @(negedge clk);
    chk("R1 ready", frame_ready, 0);
    chk("R1 bus_en", bus_en, 0);
    chk("R1 req", cmd_req, 0);
    chk("R1 start", cap_start, 0);
    chk("R1 data", host_data, 0);
    rst = 0;
    repeat (6) @(negedge clk);
    base = cmd_n; st0 = start_n;
    size_sel = 2'(s); rgb_sel = m[0];
    init_p = 1;
    wait_start(ok);
    init_p = 0;
    chk("R2 start seen", ok, 1);
    chk("R2 command count", cmd_n - base, 4);
    chk("R2 cmd0", cmd_log[base[7:0]], 16'h0A80);
    chk("R2 cmd1", cmd_log[8'(base + 1)], m ? 16'h2004 : 16'h2000);
    chk("R2 cmd2", cmd_log[8'(base + 2)], 16'h2100 + s);
    chk("R2 wake", cmd_log[8'(base + 3)], 16'h3C00);
    chk("R10 size", cap_size, s);
    chk("R10 rgb", cap_rgb, m);
    chk("R4 bus off", bus_en, 0);
    @(negedge clk);
    chk("R2 start one cycle", cap_start, 0);
    // R9 request during capture
    req_p = 1; repeat (5) @(negedge clk); req_p = 0;
    rd_n = 0; haddr = 0; repeat (6) @(negedge clk); rd_n = 1;
    chk("R9 no restart", start_n - st0, 1);
    chk("R9 no command", cmd_n - base, 4);
    chk("R4 data quiet", host_data, 0);
    send_frame(npix, f);
    chk("R5 ready rise", frame_ready, 1);
    chk("R5 bus on", bus_en, 1);
    repeat (20) @(negedge clk);
    chk("R5 sleep count", cmd_n - base, 5);
    chk("R5 sleep cmd", cmd_log[8'(base + 4)], 16'h3C01);
    for (int a = 0; a < npix; a++) read_chk(a, pix(a, f), "R6 read");
    // R7 late write ignored
    @(negedge clk); cap_we = 1; cap_addr = 1; cap_data = ~pix(1, f);
    @(negedge clk); cap_we = 0;
    read_chk(1, pix(1, f), "R7 late write");
    // R9 init outside idle
    init_p = 1; repeat (5) @(negedge clk); init_p = 0;
    repeat (12) @(negedge clk);
    chk("R9 init ignored", cmd_n - base, 5);
    chk("R9 still ready", frame_ready, 1);
    // R8 repeat capture with changed pins (R10)
    size_sel = ~size_sel; rgb_sel = ~rgb_sel;
    req_p = 1;
    wait_ready(0);
    chk("R8 ready cleared", frame_ready, 0);
    wait_start(ok);
    req_p = 0;
    chk("R8 start", ok, 1);
    chk("R8 only wake", cmd_n - base, 6);
    chk("R8 wake cmd", cmd_log[8'(base + 5)], 16'h3C00);
    chk("R10 size kept", cap_size, s);
    chk("R10 rgb kept", cap_rgb, m);
    send_frame(npix, f + 8);
    repeat (20) @(negedge clk);
    chk("R5 second sleep", cmd_log[8'(base + 6)], 16'h3C01);
    read_chk(0, pix(0, f + 8), "R6 reread first");
    read_chk(npix - 1, pix(npix - 1, f + 8), "R6 reread last");
    size_sel = 0; rgb_sel = 0;
  endtask

  initial begin
    for (int s = 0; s < 4; s++)
      for (int m = 0; m < 2; m++)
        run_cfg(s, m);
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    wait (cyc > 150000);
    if (!done_flag) begin
      done_flag = 1;
      n_checks++; n_err++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end
endmodule